// File: doc/BRIEF.md
# Fractional-Period Tick Generator

This block produces a periodic tick whose average spacing is a fractional number of clock cycles, with a resolution of 1/65536 cycle. A 16-bit counter runs freely and is never reloaded. Each tick comes from a match between that counter and a 16-bit compare value. At every match, a 32-bit accumulator advances by a programmable period word in unsigned 16.16 fixed point. The integer half of the new sum becomes the next compare value.

Each single interval is a whole number of cycles. Every tick lands on the truncation of its ideal fractional time, so the error never reaches one cycle and the long-run rate equals the period word exactly. This lets a fixed reference clock produce rates that do not divide it evenly. For example, a 16 MHz reference can give ticks at 1920, 2000 or 2400 Hz, and only the period word changes between them.

Top module: `frac_tick_gen`

## Requirements
- R1: While reset is asserted and right after it is released, tick_o is 0 and cmp_o is 0x0000. The counter and the accumulator also start at zero.
- R2: A clock edge counts as enabled when en_i is high at that edge. After reset, the first enabled edge is a match, because the counter and the compare value both equal zero. tick_o is therefore high during the cycle that follows that edge.
- R3: tick_o is high for exactly one cycle after each enabled edge at which the counter equals cmp_o. It is low after every other edge.
- R4: At each match, the accumulator becomes (accumulator + period_i) mod 2^32. Bits [31:16] of that sum appear on cmp_o in the same cycle as tick_o. Between matches, cmp_o holds its value.
- R5: Start from reset and hold period_i at 0x1A0AAAAB. After the first four ticks, cmp_o takes the values 0x1A0A, 0x3415, 0x4E20 and 0x682A, in that order.
- R6: Hold the period P constant from reset and number the ticks n = 0, 1, 2 and so on. Tick n fires on enabled edge number floor(n*P/65536), where edges are counted from 0. The timing error is therefore always below one cycle.
- R7: The counter wraps from 0xFFFF to 0 and is never cleared by a match. Wrap-around of the counter and of the accumulator needs no special handling, and ticks stay on schedule past the wrap.
- R8: period_i is sampled only at a match. An interval that is already scheduled completes unchanged. A new period value takes effect from the next addition.
- R9: While en_i is low, the counter holds its value and no tick is produced. When en_i returns high, the schedule resumes, shifted by the number of disabled edges.
- R10: Over 100,000 consecutive ticks with a constant period P, the span in cycles times 65536 differs from 100000*P by less than 65536. The average interval therefore matches P/65536 to within one part in 2^16.
- R11: At a 16 MHz reference, the three tick rates need only the period word to change: 2400 Hz uses 0x1A0AAAAB, 2000 Hz uses 0x1F400000 (exactly 8000 cycles per interval), and 1920 Hz uses 0x208D5555 (intervals of 8333 or 8334 cycles).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the counter steps on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enable: counter steps and matches are taken only while high |
| period_i | input | 32 | Tick period in cycles, unsigned 16.16 fixed point |
| tick_o | output | 1 | One-cycle pulse per match |
| cmp_o | output | 16 | Current compare value, the next match point |

## Verification
A behavioural model keeps the ideal fractional timestamp as a wide integer, and the bench compares the design against it on every cycle. The 2400 Hz word has a repeating fraction, so its compare sequence shows whether the design truncates or rounds. The exact 2000 Hz word tells constant intervals apart from dithered ones, and the 1920 Hz word tells 8333-cycle intervals apart from 8334-cycle ones. The bench changes the period just after a tick, which separates sampling at the match from sampling on every cycle. A disabled stretch followed by a long run with a near-one-cycle period pushes the counter and the accumulator through wrap-around, and that run also measures the average rate over 100,000 ticks.

// File: rtl/ftg_pkg.sv
package ftg_pkg;
    localparam int DEF_INT_W  = 16;
    localparam int DEF_FRAC_W = 16;
endpackage

// File: rtl/ftg_counter.sv
module ftg_counter #(
    parameter int W = ftg_pkg::DEF_INT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] ONE = 1;

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en_i) begin
            st_d.cnt = st_q.cnt + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

    // R9
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(cnt_o));

    // R7
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |=> (cnt_o == $past(cnt_o) + ONE));
endmodule

// File: rtl/ftg_sched.sv
module ftg_sched #(
    parameter int INT_W  = ftg_pkg::DEF_INT_W,
    parameter int FRAC_W = ftg_pkg::DEF_FRAC_W,
    localparam int ACC_W = INT_W + FRAC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_i,
    input  logic [ACC_W-1:0] period_i,
    output logic [INT_W-1:0] cmp_o,
    output logic             tick_o
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [INT_W-1:0] cmp;
        logic             tick;
    } sched_state_t;

    sched_state_t     st_d, st_q;
    logic [ACC_W-1:0] sum_d;

    always_comb begin
        st_d      = st_q;
        sum_d     = st_q.acc + period_i;
        st_d.tick = hit_i;
        if (hit_i) begin
            st_d.acc = sum_d;
            st_d.cmp = sum_d[ACC_W-1:FRAC_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmp_o  = st_q.cmp;
    assign tick_o = st_q.tick;

    // R4
    cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_i |=> $stable(cmp_o));
endmodule

// File: rtl/frac_tick_gen.sv
module frac_tick_gen #(
    parameter int INT_W  = ftg_pkg::DEF_INT_W,
    parameter int FRAC_W = ftg_pkg::DEF_FRAC_W,
    localparam int ACC_W = INT_W + FRAC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [ACC_W-1:0] period_i,
    output logic             tick_o,
    output logic [INT_W-1:0] cmp_o
);
    logic [INT_W-1:0] cnt;
    logic             hit;

    ftg_counter #(.W(INT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (en_i),
        .cnt_o (cnt)
    );

    assign hit = en_i && (cnt == cmp_o);

    ftg_sched #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_sched (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit_i    (hit),
        .period_i (period_i),
        .cmp_o    (cmp_o),
        .tick_o   (tick_o)
    );

    // R3
    match_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && (cnt == cmp_o)) |=> tick_o);

    // R9
    no_tick_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !tick_o);
endmodule

// File: tb/frac_tick_gen_test.sv
`timescale 1ns/1ps
module frac_tick_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [31:0] per = 32'h1A0AAAAB;
    logic        tick_o;
    logic [15:0] cmp_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    longint unsigned m_acc = 0;
    longint          m_k = 0;
    bit              exp_tick = 0;
    logic [15:0]     exp_cmp = '0;
    int              ntick = 0;
    longint          tick_k[$];
    logic [15:0]     cmp_log[$];

    always #10 clk = ~clk;

    frac_tick_gen uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en),
        .period_i (per),
        .tick_o   (tick_o),
        .cmp_o    (cmp_o)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // behavioural reference: ideal timestamp in 1/65536 cycle, unbounded
    always @(posedge clk) begin
        if (!rst_n) begin
            m_acc = 0; m_k = 0; exp_tick = 0; exp_cmp = '0;
        end else if (en) begin
            if (m_k == longint'(m_acc >> 16)) begin
                exp_tick = 1;
                tick_k.push_back(m_k);
                m_acc = m_acc + per;
                exp_cmp = 16'(m_acc >> 16);
                if (cmp_log.size() < 16) cmp_log.push_back(exp_cmp);
                ntick++;
            end else begin
                exp_tick = 0;
            end
            m_k++;
        end else begin
            exp_tick = 0;
        end
    end

    // per-cycle comparison (R3 tick timing, R4 compare value)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(tick_o == exp_tick, "R3 tick_o", tick_o, exp_tick);
            check(cmp_o == exp_cmp, "R4 cmp_o", cmp_o, exp_cmp);
        end
    end

    initial begin
        repeat (199000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R10 watchdog: actual=timeout expected=completion");
        report();
    end

    initial begin
        int s;
        longint d, err;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(tick_o == 1'b0, "R1 tick in reset", tick_o, 0);
        check(cmp_o == 16'h0, "R1 cmp in reset", cmp_o, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R9 idle after reset: no tick, compare still zero
        check(tick_o == 1'b0, "R9 no tick while disabled", tick_o, 0);
        check(cmp_o == 16'h0, "R1 cmp after release", cmp_o, 0);
        en = 1'b1;
        @(negedge clk);
        // R2 first enabled edge matches at zero
        check(tick_o == 1'b1, "R2 first tick", tick_o, 1);
        check(cmp_o == 16'h1A0A, "R2 cmp after first tick", cmp_o, 16'h1A0A);

        wait (ntick == 4);
        @(negedge clk);
        // R5 compare sequence at 2400 Hz word
        check(cmp_log[0] == 16'h1A0A, "R5 cmp#1", cmp_log[0], 16'h1A0A);
        check(cmp_log[1] == 16'h3415, "R5 cmp#2", cmp_log[1], 16'h3415);
        check(cmp_log[2] == 16'h4E20, "R5 cmp#3", cmp_log[2], 16'h4E20);
        check(cmp_log[3] == 16'h682A, "R5 cmp#4", cmp_log[3], 16'h682A);
        // R6 tick n at floor(n*P/65536)
        for (int n = 0; n < 4; n++) begin
            d = longint'((longint'(n) * 64'h1A0AAAAB) >> 16);
            check(tick_k[n] == d, "R6 tick index", tick_k[n], d);
        end
        // R8 change period right after a tick; scheduled point must hold
        per = 32'h1F400000;
        wait (ntick == 7);
        @(negedge clk);
        check(tick_k[4] == 64'h682A, "R8 scheduled tick kept", tick_k[4], 64'h682A);
        // R11 2000 Hz: exact 8000-cycle interval
        check(tick_k[6] - tick_k[5] == 8000, "R11 2000 Hz interval", tick_k[6] - tick_k[5], 8000);
        per = 32'h208D5555;
        wait (ntick == 10);
        @(negedge clk);
        check(tick_k[7] - tick_k[6] == 8000, "R8 old interval completes", tick_k[7] - tick_k[6], 8000);
        d = tick_k[9] - tick_k[7];
        check(d == 16666 || d == 16667, "R11 1920 Hz two intervals", d, 16667);
        check(tick_k[8] - tick_k[7] >= 8333 && tick_k[8] - tick_k[7] <= 8334,
              "R11 1920 Hz interval", tick_k[8] - tick_k[7], 8333);
        // R9 disabled stretch: no tick, schedule shifts
        en = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(tick_o == 1'b0, "R9 no tick while disabled", tick_o, 0);
        end
        en = 1'b1;
        per = 32'h00010400;
        s = 11;
        wait (ntick == s + 100001);
        @(negedge clk);
        // R10 long-run average
        d = tick_k[s + 100000] - tick_k[s];
        err = d * 65536 - 100000 * longint'(32'h00010400);
        if (err < 0) err = -err;
        check(err < 65536, "R10 average over 100000 ticks", err, 0);
        // R7 counter and accumulator wrapped while staying on schedule
        check(m_k > 65536 && cmp_o == 16'(m_acc >> 16), "R7 past wrap", cmp_o, 16'(m_acc >> 16));
        done = 1;
        report();
    end
endmodule